// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block keeps a calendar clock as eight byte-wide registers in packed BCD, with the tens digit in the upper nibble and the units digit in the lower nibble. The registers are control, seconds, minutes, hours, day of week, date, month and year. A host reaches them through a small bus with an address, a data byte and a write strobe. Reads are combinational, and writes land on the next rising clock edge.

A single-cycle `tick_1hz` pulse advances the seconds. The carry then ripples through minutes, hours, weekday, date, month and year. The date rollover accounts for month length and for leap years.

Every field write is checked against the field's legal range, and an illegal value is dropped without any effect. The seconds register also holds a stop bit that freezes counting. The weekday register also holds a century flag. Control writes have fixed bits forced.

Top module: `tod_bcd_bank`

## Requirements
- R1: After synchronous reset, the registers read as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01. The year depends on the year-base option (see R11).
- R2: A tick while not stopped and with no field write advances the seconds by one in BCD, and 0x59 wraps to 0x00 with a carry into the minutes.
- R3: The carries ripple in this order:
  - minutes wrap from 0x59 to 0x00 and carry into the hours;
  - hours wrap from 0x23 to 0x00 and carry into both the weekday and the date;
  - the weekday steps from 7 back to 1.
- R4: Date, month and year roll over as follows:
  - when the date is at or past the last day of its month, it rolls to 0x01 and carries into the month;
  - months 04, 06, 09 and 11 have 30 days, and all other months except February have 31;
  - February has 29 days when the binary year is divisible by 4, and 28 otherwise;
  - month 0x12 rolls to 0x01 and carries into the year;
  - year 0x99 rolls to 0x00.
- R5: Address 1 holds the seconds:
  - bits 6:0 are stored only when both digits are decimal and the value is 0 to 59;
  - bit 7 is the stop bit and is always stored;
  - a read returns {stop, seconds}.
- R6: While the stop bit is 1, ticks change nothing. After the stop bit is cleared by a write whose seconds field is rejected, counting resumes from the frozen value.
- R7: Each field write is accepted only when its digits are decimal and the value is in range, and is otherwise ignored:
  - minutes (address 2): bits 6:0, range 0 to 59;
  - hours (address 3): bits 5:0, range 0 to 23;
  - date (address 5): bits 5:0, range 1 to 31;
  - month (address 6): bits 4:0, range 1 to 12;
  - year (address 7): the full byte, range 0 to 99.
- R8: In the day register (address 4):
  - bits 2:0 hold the weekday, and a write updates it only for values 1 to 7;
  - bit 6 is the century flag, always stored and kept across rollovers;
  - all other bits read as 0.
- R9: A write to the control register (address 0) stores the data with bits 7 and 5 cleared and then bits 7 and 4 set, that is (data & 0x5F) | 0x90.
- R10: A write to any field register (addresses 1 to 7) in the same cycle as a tick suppresses that tick. A control write does not suppress a tick.
- R11: With the year-base option off, the reset year is 0x00. With the option on (base 1968), the reset year is 0x32, which stands for calendar year 2000.
- R12: The address map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. The read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the start date |
| tick_1hz | input | 1 | One-cycle pulse that advances the clock by one second |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
A write or a tick presented during one clock cycle is visible at `bus_rdata` after the following rising edge. The read path adds no register, so a changed address is valid at once. The bench therefore drives inputs at a falling edge, removes them at the next falling edge, and then reads the registers a nanosecond apart within the same low phase. Every tick is compared field by field against an arithmetic calendar model one cycle after it is applied, and every swept write byte is read back in the cycle after its edge.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_SEC   = 3'd1,
        A_MIN   = 3'd2,
        A_HOUR  = 3'd3,
        A_DAY   = 3'd4,
        A_DATE  = 3'd5,
        A_MONTH = 3'd6,
        A_YEAR  = 3'd7
    } tod_addr_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       cent;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } tod_state_t;

    // both nibbles hold a decimal digit
    function automatic logic bcd_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    // BCD byte to binary value (valid for any nibble pair, max 165)
    function automatic logic [7:0] bcd_bin(input logic [7:0] v);
        return ({4'b0, v[7:4]} * 8'd10) + {4'b0, v[3:0]};
    endfunction

    // add one in BCD
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/tod_wr_check.sv
`timescale 1ns/1ps
module tod_wr_check
    import tod_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    output logic              ok_sec,
    output logic              ok_min,
    output logic              ok_hour,
    output logic              ok_wday,
    output logic              ok_date,
    output logic              ok_month,
    output logic              ok_year
);

    logic [7:0] f_sec, f_hour, f_date, f_month;
    logic [7:0] v_sec, v_hour, v_date, v_month, v_year;

    always_comb begin
        f_sec   = {1'b0, wdata[6:0]};
        f_hour  = {2'b0, wdata[5:0]};
        f_date  = {2'b0, wdata[5:0]};
        f_month = {3'b0, wdata[4:0]};
        v_sec   = bcd_bin(f_sec);
        v_hour  = bcd_bin(f_hour);
        v_date  = bcd_bin(f_date);
        v_month = bcd_bin(f_month);
        v_year  = bcd_bin(wdata);

        // seconds and minutes share the same field layout and range
        ok_sec   = bcd_ok(f_sec) && (v_sec <= 8'd59);
        ok_min   = ok_sec;
        ok_hour  = bcd_ok(f_hour) && (v_hour <= 8'd23);
        ok_wday  = (wdata[2:0] != 3'd0);
        ok_date  = bcd_ok(f_date) && (v_date >= 8'd1) && (v_date <= 8'd31);
        ok_month = bcd_ok(f_month) && (v_month >= 8'd1) && (v_month <= 8'd12);
        ok_year  = bcd_ok(wdata) && (v_year <= 8'd99);
    end

endmodule

// File: rtl/tod_advance.sv
`timescale 1ns/1ps
module tod_advance
    import tod_pkg::*;
(
    input  tod_state_t cur,
    output tod_state_t nxt
);

    logic       leap;
    logic [5:0] last_day;
    logic       date_end;
    logic [7:0] year_bin;

    always_comb begin
        year_bin = bcd_bin(cur.year);
        leap     = (year_bin[1:0] == 2'b00);
        case (cur.month)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
        date_end = bcd_bin({2'b0, cur.date}) >= bcd_bin({2'b0, last_day});
    end

    always_comb begin
        nxt = cur;
        if (cur.sec != 7'h59) begin
            nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));
        end else begin
            nxt.sec = 7'h00;
            if (cur.min != 7'h59) begin
                nxt.min = 7'(bcd_inc({1'b0, cur.min}));
            end else begin
                nxt.min = 7'h00;
                if (cur.hour != 6'h23) begin
                    nxt.hour = 6'(bcd_inc({2'b0, cur.hour}));
                end else begin
                    nxt.hour = 6'h00;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (!date_end) begin
                        nxt.date = 6'(bcd_inc({2'b0, cur.date}));
                    end else begin
                        nxt.date = 6'h01;
                        if (cur.month != 5'h12) begin
                            nxt.month = 5'(bcd_inc({3'b0, cur.month}));
                        end else begin
                            nxt.month = 5'h01;
                            nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tod_rd_mux.sv
`timescale 1ns/1ps
module tod_rd_mux
    import tod_pkg::*;
(
    input  tod_state_t        st,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        case (addr)
            A_CTRL:  rdata = st.ctrl;
            A_SEC:   rdata = {st.stop, st.sec};
            A_MIN:   rdata = {1'b0, st.min};
            A_HOUR:  rdata = {2'b0, st.hour};
            A_DAY:   rdata = {1'b0, st.cent, 3'b000, st.wday};
            A_DATE:  rdata = {2'b0, st.date};
            A_MONTH: rdata = {3'b0, st.month};
            default: rdata = st.year;
        endcase
    end

endmodule

// File: rtl/tod_bcd_bank.sv
`timescale 1ns/1ps
module tod_bcd_bank
    import tod_pkg::*;
#(
    parameter bit YEAR_BASE_1968 = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [7:0] RESET_YEAR = YEAR_BASE_1968 ? 8'h32 : 8'h00;
    localparam tod_state_t RESET_STATE = '{
        ctrl: 8'h00, stop: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
        cent: 1'b0, wday: 3'd1, date: 6'h01, month: 5'h01, year: RESET_YEAR
    };

    tod_state_t q, d, adv;
    logic ok_sec, ok_min, ok_hour, ok_wday, ok_date, ok_month, ok_year;
    logic field_wr;

    tod_wr_check u_chk (
        .wdata    (bus_wdata),
        .ok_sec   (ok_sec),
        .ok_min   (ok_min),
        .ok_hour  (ok_hour),
        .ok_wday  (ok_wday),
        .ok_date  (ok_date),
        .ok_month (ok_month),
        .ok_year  (ok_year)
    );

    tod_advance u_adv (
        .cur (q),
        .nxt (adv)
    );

    tod_rd_mux u_rd (
        .st    (q),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );

    always_comb begin
        field_wr = bus_wr && (bus_addr != A_CTRL);
        d = q;
        if (tick_1hz && !q.stop && !field_wr)
            d = adv;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: d.ctrl = (bus_wdata & 8'h5F) | 8'h90;
                A_SEC: begin
                    d.stop = bus_wdata[7];
                    if (ok_sec) d.sec = bus_wdata[6:0];
                end
                A_MIN:   if (ok_min)   d.min   = bus_wdata[6:0];
                A_HOUR:  if (ok_hour)  d.hour  = bus_wdata[5:0];
                A_DAY: begin
                    d.cent = bus_wdata[6];
                    if (ok_wday) d.wday = bus_wdata[2:0];
                end
                A_DATE:  if (ok_date)  d.date  = bus_wdata[5:0];
                A_MONTH: if (ok_month) d.month = bus_wdata[4:0];
                default: if (ok_year)  d.year  = bus_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_STATE;
        else     q <= d;
    end

    AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q.sec == 7'h00 && q.date == 6'h01 && q.month == 5'h01 && q.wday == 3'd1)); // R1
    AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        bcd_ok({1'b0, q.sec}) && (q.sec <= 7'h59)); // R2
    AST_TICK_MOVES: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !q.stop && !bus_wr) |=> (q.sec != $past(q.sec))); // R2
    AST_CAL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (q.date >= 6'h01) && (q.date <= 6'h31) && (q.month >= 5'h01) && (q.month <= 5'h12)); // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (q.stop && !bus_wr) |=> (q.sec == $past(q.sec) && q.min == $past(q.min))); // R6
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MONTH && !ok_month) |=> (q.month == $past(q.month))); // R7
    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL) |=> (q.ctrl[7] && q.ctrl[4] && !q.ctrl[5])); // R9
    AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && bus_wr && bus_addr == A_MIN) |=> (q.sec == $past(q.sec))); // R10

endmodule

// File: tb/tb_tod_bcd_bank.sv
`timescale 1ns/1ps
module tb_tod_bcd_bank;

    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] rdata68;

    int total = 0;
    int bad = 0;
    int m_ctrl, m_stop, m_sec, m_min, m_hr, m_wd, m_cent, m_date, m_mon, m_yr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_bcd_bank dut (
        .clk(clk), .rst(rst), .tick_1hz(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    tod_bcd_bank #(.YEAR_BASE_1968(1'b1)) dut68 (
        .clk(clk), .rst(rst), .tick_1hz(1'b0), .bus_addr(3'd7),
        .bus_wr(1'b0), .bus_wdata(8'd0), .bus_rdata(rdata68)
    );

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int bin(input int x);
        return (x >> 4) * 10 + (x & 15);
    endfunction

    function automatic bit dec_ok(input int x, input int lo, input int hi);
        return ((x >> 4) < 10) && ((x & 15) < 10) && (bin(x) >= lo) && (bin(x) <= hi);
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            0: return 8'(m_ctrl);
            1: return 8'((m_stop << 7) | bcd(m_sec));
            2: return bcd(m_min);
            3: return bcd(m_hr);
            4: return 8'((m_cent << 6) | m_wd);
            5: return bcd(m_date);
            6: return bcd(m_mon);
            default: return bcd(m_yr);
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        bus_addr = 3'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(input string req);
        for (int a = 1; a < 8; a++) begin
            logic [7:0] v;
            rd(a, v);
            check(req, v, exp_read(a));
        end
    endtask

    task automatic model_write(input int a, input int v);
        case (a)
            0: m_ctrl = (v & 8'h5F) | 8'h90;
            1: begin m_stop = (v >> 7) & 1; if (dec_ok(v & 8'h7F, 0, 59)) m_sec = bin(v & 8'h7F); end
            2: if (dec_ok(v & 8'h7F, 0, 59)) m_min = bin(v & 8'h7F);
            3: if (dec_ok(v & 8'h3F, 0, 23)) m_hr = bin(v & 8'h3F);
            4: begin m_cent = (v >> 6) & 1; if ((v & 7) != 0) m_wd = v & 7; end
            5: if (dec_ok(v & 8'h3F, 1, 31)) m_date = bin(v & 8'h3F);
            6: if (dec_ok(v & 8'h1F, 1, 12)) m_mon = bin(v & 8'h1F);
            default: if (dec_ok(v, 0, 99)) m_yr = bin(v);
        endcase
    endtask

    task automatic model_tick();
        if (m_stop == 0) begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hr++;
                    if (m_hr == 24) begin
                        m_hr = 0;
                        m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                        if (m_date >= dim(m_mon, m_yr)) begin
                            m_date = 1; m_mon++;
                            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                        end else m_date++;
                    end
                end
            end
        end
    endtask

    task automatic put(input int a, input int v);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 8'(v); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic put_tick(input int a, input int v);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 8'(v); bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        if (a == 0) model_tick();
        model_write(a, v);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic set_time(input int yr, input int mon, input int dt, input int hr,
                            input int mi, input int sc, input int day);
        put(7, bcd(yr)); put(6, bcd(mon)); put(5, bcd(dt));
        put(3, bcd(hr)); put(2, bcd(mi)); put(1, bcd(sc)); put(4, day);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            do_tick();
            check_all(req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        m_ctrl = 0; m_stop = 0; m_sec = 0; m_min = 0; m_hr = 0;
        m_wd = 1; m_cent = 0; m_date = 1; m_mon = 1; m_yr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R12: reset values across the whole address map
        rd(0, v); check("R1 ctrl", v, 8'h00);
        rd(1, v); check("R1 sec", v, 8'h00);
        rd(2, v); check("R1 min", v, 8'h00);
        rd(3, v); check("R1 hour", v, 8'h00);
        rd(4, v); check("R12 day", v, 8'h01);
        rd(5, v); check("R1 date", v, 8'h01);
        rd(6, v); check("R1 month", v, 8'h01);
        rd(7, v); check("R11 year base off", v, 8'h00);
        check("R11 year base 1968", rdata68, 8'h32);

        // exhaustive write sweeps: R9 control, R5 seconds, R8 day, R7 others
        for (int a = 0; a < 8; a++) begin
            for (int w = 0; w < 256; w++) begin
                put(a, w);
                rd(a, v);
                if (a == 0)      check("R9", v, exp_read(a));
                else if (a == 1) check("R5", v, exp_read(a));
                else if (a == 4) check("R8", v, exp_read(a));
                else             check("R7", v, exp_read(a));
            end
        end

        // R6: stop freezes, resume from frozen value
        put(1, 8'hB0);
        for (int i = 0; i < 5; i++) begin do_tick(); check_all("R6"); end
        put(1, 8'h7F);
        rd(1, v); check("R6 resume value", v, 8'h30);
        for (int i = 0; i < 2; i++) begin do_tick(); check_all("R6"); end

        // R10: field write suppresses tick, control write does not
        put_tick(2, 8'h10); check_all("R10");
        put_tick(0, 8'h00); check_all("R10");
        rd(0, v); check("R10 ctrl", v, 8'h90);

        // R2: plain second counting and minute carry
        set_time(10, 3, 15, 8, 20, 57, 8'h02);
        run(5, "R2");

        // R4: year wrap, weekday wrap, century kept
        set_time(99, 12, 31, 23, 59, 50, 8'h47);
        run(15, "R4");
        rd(4, v); check("R8 century kept", v, 8'h41);
        // R4: February in a common and a leap year, 30-day month
        set_time(3, 2, 28, 23, 59, 58, 8'h01);
        run(5, "R4");
        set_time(4, 2, 28, 23, 59, 58, 8'h01);
        run(5, "R4");
        set_time(4, 2, 29, 23, 59, 58, 8'h01);
        run(5, "R4");
        set_time(5, 4, 30, 23, 59, 58, 8'h01);
        run(5, "R4");

        // R3: long run across minutes, hours and midnight
        set_time(12, 6, 30, 22, 58, 0, 8'h03);
        run(4000, "R3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule